// File: doc/BRIEF.md
# Code Flash Programming Sequencer

This block drives the programming mode of a small on-chip code flash. An external programmer presents an address, a data byte and an operation code, then strobes an active-low program input. The sequencer runs either a self-timed byte write or a full chip erase against a behavioural byte array. Its ready output and bit 7 of the read data both report progress while the array is busy. It also answers signature reads and applies three lock bits. Those bits restrict read-back, table reads from external code and the right to fetch code from outside the chip.

The sequencer has three named states. IDLE accepts requests. WRITE times a byte or lock-bit write. ERASE sweeps every byte back to FFh and clears the lock bits. Each transition is named:
- START_WRITE: IDLE to WRITE, on a rising program strobe carrying a write or lock operation.
- WRITE_DONE: WRITE to IDLE, after `WRITE_CYC` cycles, when the byte or lock bit is committed.
- START_ERASE: IDLE to ERASE, after the strobe is held low with the erase code for `ERASE_HOLD` consecutive cycles.
- ERASE_DONE: ERASE to IDLE, after one cycle per array byte.

Both intervals are parameters, so simulation can use short values and silicon can use the real millisecond values.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset `rdy` is 1 and all lock bits are clear, so `ext_fetch_en` equals the inverse of `ea_pin`.
- R2: A byte write starts on the clock edge that sees `prog_n` rise with `op`=1 (write). `rdy` is then 0 for exactly `WRITE_CYC` cycles, after which a verify read (`op`=0) at that address returns the byte.
- R3: While a write is busy, a verify read of the address being written returns the written byte with bit 7 inverted. Verify reads of other addresses return the array contents.
- R4: `rdy` falls only in the cycle after the program strobe was high or the erase code (`op`=2) was applied.
- R5: With `op`=2, holding `prog_n` low for `ERASE_HOLD` consecutive cycles starts an erase. Releasing the strobe earlier restarts the count. The erase keeps `rdy` at 0 for 2^`ADDR_W` cycles and leaves every byte at FFh.
- R6: A write to a byte that does not hold FFh is ignored: `rdy` stays 1 and the byte is unchanged.
- R7: Program strobes that arrive while the sequencer is busy are ignored.
- R8: A lock write (`op`=3, strobe rise) takes `WRITE_CYC` busy cycles and sets lock bit `addr[1:0]` (0, 1 or 2). With bit 0 set:
  - byte writes are ignored;
  - external table reads (`op`=5) return 00h;
  - `ext_fetch_en` uses the `ea_pin` value captured during reset instead of the live pin.
- R9: With lock bit 1 set, verify reads return 00h. With lock bit 2 set, `ext_fetch_en` is 0.
- R10: Lock bits are cleared only by a chip erase; writes and further lock writes never clear them.
- R11: A signature read (`op`=4) returns 1Eh at address 030h, 51h at 031h, and at 032h FFh (or 05h when `LOW_VOLT`=1). Any other address returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; `ea_pin` is captured while it is low |
| op | input | 3 | Operation code: 0 verify, 1 write, 2 erase, 3 lock, 4 signature, 5 external table read |
| addr | input | ADDR_W | Byte address (lock index in bits 1:0 for lock writes) |
| din | input | 8 | Data byte to write |
| prog_n | input | 1 | Active-low program strobe |
| ea_pin | input | 1 | External-access strap level |
| dout | output | 8 | Read data for the current op and address |
| rdy | output | 1 | 1 when idle, 0 while writing or erasing |
| ext_fetch_en | output | 1 | 1 when code may be fetched from external memory |

## Verification
A wrong state shows on `rdy` at the first falling edge after the edge that should have started or ended an operation. Busy lengths are therefore counted cycle by cycle against `WRITE_CYC`, `ERASE_HOLD` and the array depth. A wrong latched address or byte shows immediately through the bit 7 polling value during the write. After WRITE_DONE the wrong data shows on the first verify read. Lost or spurious lock bits show on the next table, verify or fetch-enable observation.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_ERASE
    } seq_state_t;

    localparam logic [2:0] OP_VERIFY = 3'd0;
    localparam logic [2:0] OP_WRITE  = 3'd1;
    localparam logic [2:0] OP_ERASE  = 3'd2;
    localparam logic [2:0] OP_LOCK   = 3'd3;
    localparam logic [2:0] OP_SIG    = 3'd4;
    localparam logic [2:0] OP_XTABLE = 3'd5;

    // Fixed identification bytes
    function automatic logic [7:0] sig_byte(input int unsigned a, input bit low_volt);
        case (a)
            32'h30:  return 8'h1E;
            32'h31:  return 8'h51;
            32'h32:  return low_volt ? 8'h05 : 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/flash_array.sv
module flash_array #(
    parameter int ADDR_W = 12,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data != 8'hFF) |-> mem[wr_addr] == 8'hFF); // R6

endmodule

// File: rtl/flash_lock.sv
module flash_lock (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ea_pin,
    input  logic       lock_set,
    input  logic [1:0] lock_idx,
    input  logic       lock_clr,
    output logic [2:0] lb,
    output logic       ext_fetch_en
);
    logic ea_latch;

    always_ff @(posedge clk) begin
        if (!rst_n) ea_latch <= ea_pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lb <= '0;
        end else if (lock_clr) begin
            lb <= '0;
        end else if (lock_set && lock_idx != 2'd3) begin
            lb[lock_idx] <= 1'b1;
        end
    end

    assign ext_fetch_en = ~lb[2] & ~(lb[0] ? ea_latch : ea_pin);

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_clr |=> ((lb & $past(lb)) == $past(lb))); // R10

endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int WRITE_CYC  = 150,
    parameter int ERASE_HOLD = 1000,
    localparam int DEPTH     = 1 << ADDR_W,
    localparam int CNT_MAX   = (DEPTH > WRITE_CYC) ? DEPTH : WRITE_CYC,
    localparam int CNT_W     = $clog2(CNT_MAX) + 1,
    localparam int HOLD_W    = $clog2(ERASE_HOLD) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              prog_n,
    input  logic              wr_blocked,
    output seq_state_t        st,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              lock_set,
    output logic              lock_clr,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [7:0]        lat_data,
    output logic              lat_lock
);
    seq_state_t        st_nx;
    logic              prog_q;
    logic              rise;
    logic              erase_cond;
    logic [CNT_W-1:0]  cnt;
    logic [HOLD_W-1:0] hold;
    logic              write_last;
    logic              erase_last;

    assign rise       = prog_n & ~prog_q;
    assign erase_cond = (st == ST_IDLE) && !prog_n && (op == OP_ERASE);
    assign write_last = (cnt == CNT_W'(WRITE_CYC - 1));
    assign erase_last = (cnt == CNT_W'(DEPTH - 1));

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (rise && op == OP_WRITE && !wr_blocked)      st_nx = ST_WRITE;
                else if (rise && op == OP_LOCK)                 st_nx = ST_WRITE;
                else if (erase_cond && hold == HOLD_W'(ERASE_HOLD - 1)) st_nx = ST_ERASE;
            end
            ST_WRITE: if (write_last) st_nx = ST_IDLE;
            ST_ERASE: if (erase_last) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // State register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            prog_q   <= 1'b1;
            cnt      <= '0;
            hold     <= '0;
            lat_addr <= '0;
            lat_data <= '0;
            lat_lock <= 1'b0;
        end else begin
            st     <= st_nx;
            prog_q <= prog_n;
            cnt    <= (st_nx != st) ? '0 : cnt + 1'b1;
            hold   <= (erase_cond && st_nx == ST_IDLE) ? hold + 1'b1 : '0;
            if (st == ST_IDLE && st_nx == ST_WRITE) begin
                lat_addr <= addr;
                lat_data <= din;
                lat_lock <= (op == OP_LOCK);
            end
        end
    end

    // Outputs
    always_comb begin
        wr_en    = 1'b0;
        wr_addr  = lat_addr;
        wr_data  = lat_data;
        lock_set = 1'b0;
        lock_clr = 1'b0;
        unique case (st)
            ST_WRITE: begin
                wr_en    = write_last && !lat_lock;
                lock_set = write_last && lat_lock;
            end
            ST_ERASE: begin
                wr_en    = 1'b1;
                wr_addr  = cnt[ADDR_W-1:0];
                wr_data  = 8'hFF;
                lock_clr = erase_last;
            end
            default: ;
        endcase
    end

    AST_START_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !(prog_n && !prog_q)) |=> st != ST_WRITE); // R2

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int WRITE_CYC  = 150,
    parameter int ERASE_HOLD = 1000,
    parameter bit LOW_VOLT   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              prog_n,
    input  logic              ea_pin,
    output logic [7:0]        dout,
    output logic              rdy,
    output logic              ext_fetch_en
);
    seq_state_t        st;
    logic              wr_en, lock_set, lock_clr, lat_lock, wr_blocked;
    logic [ADDR_W-1:0] wr_addr, lat_addr;
    logic [7:0]        wr_data, lat_data, rd_data;
    logic [2:0]        lb;

    assign wr_blocked = lb[0] || (rd_data != 8'hFF);

    flash_ctrl #(.ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC), .ERASE_HOLD(ERASE_HOLD)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .din(din), .prog_n(prog_n),
        .wr_blocked(wr_blocked), .st(st), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lock_set(lock_set), .lock_clr(lock_clr),
        .lat_addr(lat_addr), .lat_data(lat_data), .lat_lock(lat_lock)
    );

    flash_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(addr), .rd_data(rd_data)
    );

    flash_lock u_lock (
        .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin), .lock_set(lock_set),
        .lock_idx(lat_addr[1:0]), .lock_clr(lock_clr), .lb(lb),
        .ext_fetch_en(ext_fetch_en)
    );

    assign rdy = (st == ST_IDLE);

    always_comb begin
        case (op)
            OP_VERIFY: begin
                if (st == ST_WRITE && !lat_lock && addr == lat_addr)
                    dout = {~lat_data[7], lat_data[6:0]};
                else
                    dout = lb[1] ? 8'h00 : rd_data;
            end
            OP_SIG:    dout = sig_byte(32'(addr), LOW_VOLT);
            OP_XTABLE: dout = lb[0] ? 8'h00 : rd_data;
            default:   dout = 8'h00;
        endcase
    end

    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> ($past(prog_n) || $past(op) == OP_ERASE)); // R4

endmodule

// File: tb/flash_prog_seq_bench.sv
module flash_prog_seq_bench;
    localparam int AW = 12;
    localparam int DEPTH = 1 << AW;
    localparam int W = 20;
    localparam int H = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic          prog_n = 1'b1;
    logic          ea_pin = 1'b0;
    logic [7:0]    dout;
    logic          rdy, ext_fetch_en;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] model [DEPTH];
    logic [2:0] lb_m = '0;

    always #5 clk = ~clk;

    flash_prog_seq #(.ADDR_W(AW), .WRITE_CYC(W), .ERASE_HOLD(H), .LOW_VOLT(1'b0)) u_flash_prog_seq (
        .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .din(din), .prog_n(prog_n),
        .ea_pin(ea_pin), .dout(dout), .rdy(rdy), .ext_fetch_en(ext_fetch_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit write_ok(input int a);
        return model[a] == 8'hFF && !lb_m[0];
    endfunction

    function automatic logic [7:0] exp_verify(input int a);
        return lb_m[1] ? 8'h00 : model[a];
    endfunction

    task automatic rd(input logic [2:0] o, input int a, output logic [7:0] v);
        @(negedge clk);
        op = o; addr = AW'(a);
        #1 v = dout;
    endtask

    // Strobe; returns at the negedge after the clock that saw the rise
    task automatic pulse(input logic [2:0] o, input int a, input logic [7:0] d);
        @(negedge clk);
        op = o; addr = AW'(a); din = d; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (!rdy && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_write(input string req, input int a, input logic [7:0] d);
        int n;
        bit ok;
        logic [7:0] v;
        ok = write_ok(a);
        pulse(3'd1, a, d);
        chk(req, rdy, !ok);
        wait_idle(n);
        if (ok) begin
            chk(req, n, W);
            model[a] = d;
        end
        rd(3'd0, a, v);
        chk(req, v, exp_verify(a));
    endtask

    task automatic do_lock(input int idx);
        int n;
        pulse(3'd3, idx, 8'h00);
        chk("R8", rdy, 0);
        wait_idle(n);
        chk("R8", n, W);
        lb_m[idx] = 1'b1;
    endtask

    task automatic do_erase();
        int n;
        @(negedge clk);
        op = 3'd2; prog_n = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rdy && n < 1000);
        chk("R5", n, H);
        prog_n = 1'b1;
        wait_idle(n);
        chk("R5", n, DEPTH);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        lb_m = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n, a;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1", rdy, 1);
        chk("R1", ext_fetch_en, 1);
        ea_pin = 1'b1; #1 chk("R1", ext_fetch_en, 0);
        ea_pin = 1'b0;

        // R5 early release restarts count
        @(negedge clk);
        op = 3'd2; prog_n = 1'b0;
        repeat (H - 5) @(negedge clk);
        prog_n = 1'b1;
        repeat (3) begin @(negedge clk); chk("R5", rdy, 1); end
        do_erase();
        rd(3'd0, 0, v);         chk("R5", v, 8'hFF);
        rd(3'd0, DEPTH - 1, v); chk("R5", v, 8'hFF);

        // R2 clean write
        do_write("R2", 16, 8'h3C);

        // R3 polling, R7 busy strobe ignored
        pulse(3'd1, 12'h123, 8'h5A);
        chk("R2", rdy, 0);
        rd(3'd0, 12'h123, v); chk("R3", v, 8'hDA);
        rd(3'd0, 12'h124, v); chk("R3", v, 8'hFF);
        pulse(3'd1, 12'h200, 8'h11);
        chk("R7", rdy, 0);
        wait_idle(n);
        model[12'h123] = 8'h5A;
        rd(3'd0, 12'h123, v); chk("R2", v, 8'h5A);
        rd(3'd0, 12'h200, v); chk("R7", v, 8'hFF);

        // R6 rewrite of programmed byte
        do_write("R6", 12'h123, 8'h00);

        // Random writes over a small window to hit programmed bytes
        for (int i = 0; i < 40; i++) begin
            a = int'($urandom % 64);
            do_write(write_ok(a) ? "R2" : "R6", a, 8'($urandom));
        end

        // R11 signature
        rd(3'd4, 12'h030, v); chk("R11", v, 8'h1E);
        rd(3'd4, 12'h031, v); chk("R11", v, 8'h51);
        rd(3'd4, 12'h032, v); chk("R11", v, 8'hFF);
        rd(3'd4, 12'h033, v); chk("R11", v, 8'h00);

        // R8 lock bit 0
        rd(3'd5, 12'h123, v); chk("R8", v, 8'h5A);
        do_lock(0);
        rd(3'd5, 12'h123, v); chk("R8", v, 8'h00);
        do_write("R8", 12'h300, 8'h77);
        ea_pin = 1'b1; #1 chk("R8", ext_fetch_en, 1);

        // R9 lock bits 1 and 2, R10 sticky
        do_lock(1);
        rd(3'd0, 12'h123, v); chk("R9", v, 8'h00);
        do_lock(2);
        chk("R9", ext_fetch_en, 0);
        rd(3'd5, 12'h123, v); chk("R10", v, 8'h00);

        // R10 erase clears locks
        do_erase();
        rd(3'd0, 12'h123, v); chk("R10", v, 8'hFF);
        chk("R10", ext_fetch_en, 0);
        ea_pin = 1'b0; #1 chk("R10", ext_fetch_en, 1);
        do_write("R10", 12'h300, 8'h77);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule